// File: doc/BRIEF.md
# PS/2 Host Port Register Interface

This block is the register face of a keyboard or mouse serial port. A processor reaches it through a simple word-addressed slave with separate read and write strobes and a byte offset. Received bytes from the line side come in as a valid/byte stream and wait in a small queue. Bytes the processor writes go out as a one-cycle strobe with data. The line protocol itself is handled elsewhere. The block keeps a control word, a clock divisor word and the last byte read, and it exposes a constant identification area near the top of its 4 KiB window.

A single level-sensitive interrupt output is driven from the control word and the queue state. The receive-enable bit raises it while any byte waits. The transmit-enable bit raises it unconditionally, because the transmitter here is always reported ready. Read data is registered: it appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `ps2h_port`

## Requirements
- R1: After reset, the control and divisor words, the last-byte holder and the queue are all zero, `irq` is low, `tx_strobe` is low and `bus_rdata` is zero.
- R2: Word index 0 (byte offset 0x000) is the control register. It reads back what was written. `irq` is high while control bit 4 is set and the queue is not empty, and it takes its new value in the cycle after the control write.
- R3: While control bit 3 is set, `irq` is high regardless of the queue.
- R4: A read of word index 1 (offset 0x004) returns 0x10 when the queue holds a byte and 0x00 when it is empty.
- R5: A read of word index 2 (offset 0x008) with a byte queued removes the oldest byte, keeps it as the last value and returns it zero-extended. Bytes come out in arrival order.
- R6: A read of word index 2 with an empty queue returns the kept last value again and changes nothing.
- R7: The queue holds 4 bytes. A byte offered while it is full is dropped.
- R8: A read of word index 4 (offset 0x010) returns bit 1 set and bit 0 equal to the queue-not-empty flag, with all other bits zero.
- R9: A write to word index 2 raises `tx_strobe` for exactly one cycle, in the cycle after the write, with `tx_byte` equal to the low 8 bits of the written word.
- R10: Word index 3 (offset 0x00C) is a divisor word that reads back what was written and affects nothing else.
- R11: A read at byte offsets 0xFE0 to 0xFFF returns identification byte number (offset − 0xFE0) >> 2 from the list 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: A read from any other offset returns zero. Writes to word indices 1 and 4, and to any unlisted offset, change no register and produce no transmit strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (12) | Byte offset in the window |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data, valid the cycle after `bus_rd` |
| rx_valid | input | 1 | A received byte is offered |
| rx_byte | input | 8 | Received byte |
| tx_strobe | output | 1 | One-cycle send request |
| tx_byte | output | 8 | Byte to send |
| irq | output | 1 | Level interrupt |

## Verification
Embedded assertions watch every cycle for several things: that the queue never exceeds its depth and is never popped empty, that a full queue drops an incoming byte, that a transmit-enable write raises the interrupt, that every data write yields exactly one strobe carrying its low byte, that status and empty-queue data reads return what the queue state implies, and that the divisor only moves on its own write. Other behaviours can only be shown by the bench's scenarios against its behavioural model. These are the arrival order of queued bytes, the identification sequence, the return to zero after the queue drains, and the absence of side effects from writes to read-only or unlisted offsets.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_DATA  = 2;
  localparam int IDX_DIV   = 3;
  localparam int IDX_IIR   = 4;
  localparam int CTRL_RXIE = 4;
  localparam int CTRL_TXIE = 3;
  localparam logic [7:0] STAT_PEND = 8'h10;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ps2h_rx_fifo.sv
module ps2h_rx_fifo #(
  parameter int BW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [BW-1:0] din,
  input  logic          pop,
  output logic [BW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [BW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          acc, take;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign acc   = push && !full;
  assign take  = pop && !empty;
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (acc) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (acc)  wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (take) rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      case ({acc, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/ps2h_irq_gen.sv
module ps2h_irq_gen (
  input  logic rx_en,
  input  logic tx_en,
  input  logic pending,
  output logic irq
);
  assign irq = (rx_en && pending) || tx_en;
endmodule

// File: rtl/ps2h_port.sv
module ps2h_port #(
  parameter int DW         = 32,
  parameter int AW         = 12,
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          tx_strobe,
  output logic [7:0]    tx_byte,
  output logic          irq
);
  import ps2h_pkg::*;

  localparam int IW = AW - 2;
  localparam logic [AW-1:0] ID_LO = AW'(12'hFE0);
  localparam logic [AW-1:0] ID_HI = AW'(12'hFFF);

  logic [DW-1:0] ctrl_q, div_q, rdata_d;
  logic [7:0]    last_q, fifo_dout;
  logic [IW-1:0] widx;
  logic          in_id, sel_ctrl, sel_stat, sel_data, sel_div, sel_iir;
  logic          empty, full, pending, pop;
  logic [AW-1:0] id_off;

  assign widx     = bus_addr[AW-1:2];
  assign in_id    = (bus_addr >= ID_LO) && (bus_addr <= ID_HI);
  assign id_off   = bus_addr - ID_LO;
  assign sel_ctrl = !in_id && (widx == IW'(IDX_CTRL));
  assign sel_stat = !in_id && (widx == IW'(IDX_STAT));
  assign sel_data = !in_id && (widx == IW'(IDX_DATA));
  assign sel_div  = !in_id && (widx == IW'(IDX_DIV));
  assign sel_iir  = !in_id && (widx == IW'(IDX_IIR));
  assign pending  = !empty;
  assign pop      = bus_rd && sel_data && pending;

  ps2h_rx_fifo #(.BW(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(rx_valid), .din(rx_byte),
    .pop(pop), .dout(fifo_dout),
    .empty(empty), .full(full)
  );

  ps2h_irq_gen u_irq (
    .rx_en(ctrl_q[CTRL_RXIE]),
    .tx_en(ctrl_q[CTRL_TXIE]),
    .pending(pending),
    .irq(irq)
  );

  always_comb begin
    rdata_d = '0;
    if (in_id)         rdata_d = DW'(id_byte(id_off[4:2]));
    else if (sel_ctrl) rdata_d = ctrl_q;
    else if (sel_stat) rdata_d = pending ? DW'(STAT_PEND) : '0;
    else if (sel_data) rdata_d = pending ? DW'(fifo_dout) : DW'(last_q);
    else if (sel_div)  rdata_d = div_q;
    else if (sel_iir)  rdata_d = DW'({1'b1, pending});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      last_q    <= '0;
      bus_rdata <= '0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= bus_wr && sel_data;
      if (bus_wr && sel_data) tx_byte <= bus_wdata[7:0];
      if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata;
      if (bus_wr && sel_div)  div_q  <= bus_wdata;
      if (pop)                last_q <= fifo_dout;
      if (bus_rd)             bus_rdata <= rdata_d;
    end
  end

  a_r3_txie_raises: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_ctrl && bus_wdata[CTRL_TXIE]) |=> irq);
  a_r9_tx_one_shot: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_data) |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));
  a_r9_no_stray_tx: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && sel_data) |=> !tx_strobe);
  a_r4_status: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_stat) |=> (bus_rdata == ($past(empty) ? '0 : DW'(STAT_PEND))));
  a_r6_empty_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_data && empty) |=> (bus_rdata == DW'($past(last_q)) && $stable(last_q)));
  a_r10_div_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && sel_div) |=> $stable(div_q));
endmodule

// File: tb/ps2h_port_bench.sv
module ps2h_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_strobe, irq;
  logic [7:0]  tx_byte;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  ps2h_port u_ps2h_port (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  // behavioural reference
  byte unsigned q[$];
  logic [31:0] m_ctrl, m_div, m_rdata;
  logic [7:0]  m_last, m_txb;
  logic        m_txs, m_irq;

  function automatic logic [7:0] ref_id(input int n);
    byte unsigned t[8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[n];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_ctrl = 0; m_div = 0; m_rdata = 0; m_last = 0; m_txb = 0; m_txs = 0;
    end else begin
      automatic int sz0 = q.size();
      automatic int a = bus_addr;
      m_txs = 0;
      if (bus_rd) begin
        if (a >= 'hFE0) m_rdata = ref_id((a - 'hFE0) / 4);
        else case (a / 4)
          0: m_rdata = m_ctrl;
          1: m_rdata = (sz0 != 0) ? 32'h10 : 32'h0;
          2: begin
               if (sz0 != 0) m_last = q.pop_front();
               m_rdata = {24'h0, m_last};
             end
          3: m_rdata = m_div;
          4: m_rdata = {30'h0, 1'b1, sz0 != 0};
          default: m_rdata = 0;
        endcase
      end
      if (bus_wr && a < 'hFE0) begin
        case (a / 4)
          0: m_ctrl = bus_wdata;
          2: begin m_txs = 1; m_txb = bus_wdata[7:0]; end
          3: m_div = bus_wdata;
          default: ;
        endcase
      end
      if (rx_valid && sz0 < 4) q.push_back(rx_byte);
    end
    m_irq = ((q.size() != 0) && m_ctrl[4]) || m_ctrl[3];
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (bus_rdata !== m_rdata || irq !== m_irq || tx_strobe !== m_txs ||
          (m_txs && tx_byte !== m_txb)) begin
        errors++;
        $display("FAIL %s: rdata=%h irq=%b txs=%b txb=%h expected rdata=%h irq=%b txs=%b txb=%h",
                 cur_req, bus_rdata, irq, tx_strobe, tx_byte, m_rdata, m_irq, m_txs, m_txb);
      end
    end
  end

  task automatic expect_rd(input string req, input logic [31:0] exp);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", req, bus_rdata, exp);
    end
  endtask

  task automatic expect_irq(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", req, irq, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    expect_rd("R1", 32'h0);
    expect_irq("R1", 1'b0);

    cur_req = "R11";
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(4 * i));
      expect_rd("R11", {24'h0, ref_id(i)});
    end
    rd(12'hFF5);
    expect_rd("R11", 32'hF0);

    cur_req = "R2";
    wr(12'h000, 32'h0000_0010);
    rd(12'h000);
    expect_rd("R2", 32'h10);
    expect_irq("R2", 1'b0);
    rx(8'h3C);
    expect_irq("R2", 1'b1);

    cur_req = "R4";
    rd(12'h004);
    expect_rd("R4", 32'h10);
    cur_req = "R8";
    rd(12'h010);
    expect_rd("R8", 32'h3);
    cur_req = "R5";
    rd(12'h008);
    expect_rd("R5", 32'h3C);
    expect_irq("R2", 1'b0);
    cur_req = "R4";
    rd(12'h004);
    expect_rd("R4", 32'h0);
    cur_req = "R8";
    rd(12'h010);
    expect_rd("R8", 32'h2);
    cur_req = "R6";
    rd(12'h008);
    expect_rd("R6", 32'h3C);

    cur_req = "R3";
    wr(12'h000, 32'h0000_0008);
    expect_irq("R3", 1'b1);
    wr(12'h000, 32'h0);
    expect_irq("R3", 1'b0);

    cur_req = "R7";
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      rx_valid = 1; rx_byte = 8'hA0 + 8'(i);
      @(negedge clk);
    end
    rx_valid = 0;
    for (int i = 0; i < 4; i++) begin
      rd(12'h008);
      expect_rd("R7", 32'hA0 + 32'(i));
    end
    rd(12'h008);
    expect_rd("R6", 32'hA3);

    cur_req = "R5";
    @(negedge clk); rx_valid = 1; rx_byte = 8'h77; bus_rd = 1; bus_addr = 12'h008;
    @(negedge clk); rx_valid = 0; bus_rd = 0;
    expect_rd("R6", 32'hA3);
    rd(12'h008);
    expect_rd("R5", 32'h77);

    cur_req = "R9";
    wr(12'h008, 32'h0000_01A5);
    wr(12'h008, 32'h0000_005E);

    cur_req = "R10";
    wr(12'h00C, 32'hDEAD_0042);
    rd(12'h00C);
    expect_rd("R10", 32'hDEAD_0042);

    cur_req = "R12";
    wr(12'h000, 32'h0000_0010);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'hFE4, 32'hFFFF_FFFF);
    expect_irq("R12", 1'b0);
    rd(12'h000);
    expect_rd("R12", 32'h10);
    rd(12'h00C);
    expect_rd("R12", 32'hDEAD_0042);
    rd(12'h040);
    expect_rd("R12", 32'h0);
    rd(12'h7FC);
    expect_rd("R12", 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule